// File: doc/BRIEF.md
# UART Receive Error Status and Tagged Receive Buffer

This block sits behind a UART receiver core and keeps the receive-side error state that software sees. Each clock, the core may hand over one finished frame: a data byte, the sampled stop bit, whether the received parity matched, and whether noise was seen while sampling. The block decides whether the frame is accepted. Accepted words go into a small FIFO, and each entry carries its own parity-error tag and noise tag. The block also updates four sticky flags: noise, framing, parity and overrun.

The flags describe the history since they were last cleared. They do not say which buffered word had the error. To find that, software reads the head entry's tags before it pops the word with a data read. All flags are cleared by one two-step access: a status read while any flag is set, then a data read. A framing error stops reception until that clear happens. Enabling break detection suppresses the framing and parity flags.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `uart_rx_err_status`

## Requirements
- R1: While reset is asserted, and after it is released, all four flags are 0, `rx_avail` is 0, and the buffer holds nothing.
- R2: Accepted words leave the buffer in arrival order, and the buffer holds up to 4 entries. `rx_data`, `rx_tag_par` and `rx_tag_noise` show the oldest entry whenever `rx_avail` is 1. A pulse on `rd_data` removes that entry. `rd_data` has no effect on the buffer when it is empty.
- R3: `err_frame` sets when an accepted frame has `frm_stop_bit` = 0 and `cfg_brk_det_en` = 0. That word is still stored in the buffer.
- R4: While `err_frame` is 1, a frame presented on `frm_valid` is discarded. It changes neither the buffer nor any flag.
- R5: `err_parity` and the stored parity tag set only for an accepted frame with `cfg_par_en` = 1, `cfg_brk_det_en` = 0 and `frm_par_ok` = 0.
- R6: `err_noise` and the stored noise tag set for any accepted frame with `frm_noise` = 1.
- R7: A frame that arrives when the buffer holds 4 entries, with no `rd_data` in the same cycle, is discarded and sets `err_overrun`. No other flag changes because of it. If `rd_data` comes in the same cycle, the frame is accepted.
- R8: A `rd_stat` pulse while any flag is 1 arms the clear. The next `rd_data` pulse then clears every flag and disarms. A `rd_data` pulse while not armed leaves the flags unchanged.
- R9: When a flag is set by a frame in the same cycle as its clearing `rd_data`, the flag ends up 1.
- R10: Flags and buffer outputs reflect a frame or a read after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle pulse: a finished frame is presented |
| frm_data | input | 8 | Received data byte |
| frm_stop_bit | input | 1 | Sampled stop bit level |
| frm_par_ok | input | 1 | 1 when the received parity bit matched |
| frm_noise | input | 1 | 1 when noise was detected in the frame |
| cfg_par_en | input | 1 | Parity checking enabled |
| cfg_brk_det_en | input | 1 | Break detection enabled |
| rd_stat | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe; pops the head entry |
| rx_data | output | 8 | Data byte of the head entry |
| rx_tag_par | output | 1 | Parity-error tag of the head entry |
| rx_tag_noise | output | 1 | Noise tag of the head entry |
| rx_avail | output | 1 | Buffer is not empty |
| err_noise | output | 1 | Sticky noise flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
Every result is one register stage away from its stimulus. A frame, a status read or a data read presented before a rising edge shows up on the flags, the head entry and `rx_avail` right after that edge. The bench drives inputs on the falling edge and advances its reference model at the following rising edge. It compares every output at the next falling edge, so each check lands on the cycle in which R10 says the result is due. The two-step clear and the same-cycle set-versus-clear case are built from consecutive one-cycle strobes, so R8 and R9 are checked on the exact edge where the clear would take effect.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NFLAG = 4;

  localparam int FLG_NOISE  = 0;
  localparam int FLG_FRAME  = 1;
  localparam int FLG_PARITY = 2;
  localparam int FLG_OVR    = 3;

  localparam int TAG_W = 2;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxerr_rst_sync.sv
module rxerr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/rxerr_qual.sv
module rxerr_qual
  import rxerr_pkg::*;
(
  input  logic      frm_valid,
  input  logic      frm_stop_bit,
  input  logic      frm_par_ok,
  input  logic      frm_noise,
  input  logic      cfg_par_en,
  input  logic      cfg_brk_det_en,
  input  logic      rd_data,
  input  logic      rx_blocked,
  input  logic      buf_full,
  input  logic      buf_empty,
  output logic      buf_push,
  output logic      buf_pop,
  output logic      tag_par,
  output logic      tag_noise,
  output flag_vec_t set_vec
);
  logic attempt;
  logic room;
  logic lost;
  logic checked;

  always_comb begin
    buf_pop  = rd_data & ~buf_empty;
    attempt  = frm_valid & ~rx_blocked;
    room     = ~buf_full | buf_pop;
    buf_push = attempt & room;
    lost     = attempt & ~room;
    checked  = buf_push & ~cfg_brk_det_en;

    tag_par   = checked & cfg_par_en & ~frm_par_ok;
    tag_noise = buf_push & frm_noise;

    set_vec             = '0;
    set_vec[FLG_NOISE]  = tag_noise;
    set_vec[FLG_FRAME]  = checked & ~frm_stop_bit;
    set_vec[FLG_PARITY] = tag_par;
    set_vec[FLG_OVR]    = lost;
  end
endmodule

// File: rtl/rxerr_flags.sv
module rxerr_flags
  import rxerr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      rd_stat,
  input  logic      rd_data,
  output flag_vec_t flags,
  output logic      armed
);
  flag_vec_t flg_q;
  flag_vec_t flg_d;
  flag_vec_t flg_en;
  logic      armed_q;
  logic      armed_d;
  logic      armed_en;
  logic      clr;
  logic      any_set;

  always_comb begin
    any_set  = |flg_q;
    clr      = rd_data & armed_q;
    flg_d    = set_vec | (flg_q & {NFLAG{~clr}});
    flg_en   = set_vec | {NFLAG{clr}};
    armed_en = rd_data | (rd_stat & any_set);
    armed_d  = ~rd_data;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q[i] <= 1'b0;
      end else if (flg_en[i]) begin
        flg_q[i] <= flg_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  assign flags = flg_q;
  assign armed = armed_q;
endmodule

// File: rtl/rxerr_fifo.sv
module rxerr_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             wdata,
  output logic [WIDTH-1:0]             head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d;
  logic [AW-1:0]    rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ptr_en;

  always_comb begin
    wr_d   = push ? ((wr_q == LAST) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d   = pop  ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d  = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
    ptr_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic we;
    assign we = push && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (we) mem[i] <= wdata;
    end
  end

  assign head  = mem[rd_q];
  assign full  = (cnt_q == FULLC);
  assign empty = (cnt_q == '0);
  assign occ   = cnt_q;
endmodule

// File: rtl/uart_rx_err_status.sv
module uart_rx_err_status
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_stop_bit,
  input  logic              frm_par_ok,
  input  logic              frm_noise,
  input  logic              cfg_par_en,
  input  logic              cfg_brk_det_en,
  input  logic              rd_stat,
  input  logic              rd_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_tag_par,
  output logic              rx_tag_noise,
  output logic              rx_avail,
  output logic              err_noise,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  localparam int ENT_W = DATA_W + TAG_W;
  localparam int CW    = $clog2(DEPTH+1);

  logic             rst_n_s;
  logic             buf_push, buf_pop, buf_full, buf_empty;
  logic             tag_par, tag_noise;
  logic [ENT_W-1:0] wr_ent, head_ent;
  logic [CW-1:0]    occ;
  flag_vec_t        set_vec, flags;
  logic             armed;

  rxerr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rxerr_qual u_qual (
    .frm_valid      (frm_valid),
    .frm_stop_bit   (frm_stop_bit),
    .frm_par_ok     (frm_par_ok),
    .frm_noise      (frm_noise),
    .cfg_par_en     (cfg_par_en),
    .cfg_brk_det_en (cfg_brk_det_en),
    .rd_data        (rd_data),
    .rx_blocked     (flags[FLG_FRAME]),
    .buf_full       (buf_full),
    .buf_empty      (buf_empty),
    .buf_push       (buf_push),
    .buf_pop        (buf_pop),
    .tag_par        (tag_par),
    .tag_noise      (tag_noise),
    .set_vec        (set_vec)
  );

  assign wr_ent = {tag_noise, tag_par, frm_data};

  rxerr_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (buf_push),
    .pop   (buf_pop),
    .wdata (wr_ent),
    .head  (head_ent),
    .full  (buf_full),
    .empty (buf_empty),
    .occ   (occ)
  );

  rxerr_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_vec (set_vec),
    .rd_stat (rd_stat),
    .rd_data (rd_data),
    .flags   (flags),
    .armed   (armed)
  );

  assign rx_data      = head_ent[DATA_W-1:0];
  assign rx_tag_par   = head_ent[DATA_W];
  assign rx_tag_noise = head_ent[DATA_W+1];
  assign rx_avail     = ~buf_empty;
  assign err_noise    = flags[FLG_NOISE];
  assign err_frame    = flags[FLG_FRAME];
  assign err_parity   = flags[FLG_PARITY];
  assign err_overrun  = flags[FLG_OVR];
endmodule

// File: rtl/uart_rx_err_status_chk.sv
module uart_rx_err_status_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid,
  input logic          frm_stop_bit,
  input logic          cfg_par_en,
  input logic          cfg_brk_det_en,
  input logic          rd_data,
  input logic          err_noise,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_overrun,
  input logic          armed,
  input logic [CW-1:0] occ
);
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_frame_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !err_frame && occ != CW'(DEPTH) && !frm_stop_bit && !cfg_brk_det_en
    |=> err_frame);

  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame && !rd_data |=> occ == $past(occ));

  p_par_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_parity && (cfg_brk_det_en || !cfg_par_en) |=> !err_parity);

  p_ovr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !err_frame && occ == CW'(DEPTH) && !rd_data
    |=> err_overrun && err_noise == $past(err_noise)
        && err_parity == $past(err_parity) && err_frame == $past(err_frame));

  p_noarm_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !armed && err_noise |=> err_noise);
endmodule

bind uart_rx_err_status uart_rx_err_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_s),
  .frm_valid      (frm_valid),
  .frm_stop_bit   (frm_stop_bit),
  .cfg_par_en     (cfg_par_en),
  .cfg_brk_det_en (cfg_brk_det_en),
  .rd_data        (rd_data),
  .err_noise      (err_noise),
  .err_frame      (err_frame),
  .err_parity     (err_parity),
  .err_overrun    (err_overrun),
  .armed          (armed),
  .occ            (occ)
);

// File: tb/sim_uart_rx_err_status.sv
module sim_uart_rx_err_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_data = '0;
  logic       frm_stop_bit = 1'b1;
  logic       frm_par_ok = 1'b1;
  logic       frm_noise = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_brk_det_en = 1'b0;
  logic       rd_stat = 1'b0;
  logic       rd_data = 1'b0;
  logic [7:0] rx_data;
  logic       rx_tag_par, rx_tag_noise, rx_avail;
  logic       err_noise, err_frame, err_parity, err_overrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int q[$];
  bit m_fn, m_ff, m_fp, m_fo, m_arm;

  always #5 clk = ~clk;

  uart_rx_err_status u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(err_noise == m_fn, "R6 err_noise", err_noise, m_fn);
    chk(err_frame == m_ff, "R3 err_frame", err_frame, m_ff);
    chk(err_parity == m_fp, "R5 err_parity", err_parity, m_fp);
    chk(err_overrun == m_fo, "R7 err_overrun", err_overrun, m_fo);
    chk(rx_avail == (q.size() > 0), "R2 rx_avail", rx_avail, q.size() > 0);
    if (q.size() > 0)
      chk({rx_tag_noise, rx_tag_par, rx_data} == q[0][9:0], "R2 head entry",
          {rx_tag_noise, rx_tag_par, rx_data}, q[0]);
  endtask

  // one clock: drive at falling edge, model steps at the rising edge,
  // outputs compared at the next falling edge (R10: one edge of latency)
  task automatic cyc(input bit v, input int d, input bit stop, input bit pok,
                     input bit nz, input bit pen, input bit bke,
                     input bit rs, input bit rd);
    bit try_, room, push, lost, pop, clr, chkd, pe, fe, ne, anyf;
    frm_valid = v; frm_data = d[7:0]; frm_stop_bit = stop; frm_par_ok = pok;
    frm_noise = nz; cfg_par_en = pen; cfg_brk_det_en = bke;
    rd_stat = rs; rd_data = rd;
    pop   = rd && q.size() > 0;
    try_  = v && !m_ff;
    room  = q.size() < 4 || pop;
    push  = try_ && room;
    lost  = try_ && !room;
    chkd  = push && !bke;
    pe    = chkd && pen && !pok;
    fe    = chkd && !stop;
    ne    = push && nz;
    clr   = rd && m_arm;
    anyf  = m_fn | m_ff | m_fp | m_fo;
    @(posedge clk);
    if (pop) void'(q.pop_front());
    if (push) q.push_back((d & 8'hff) | (int'(pe) << 8) | (int'(ne) << 9));
    m_fn = ne   | (m_fn & !clr);
    m_ff = fe   | (m_ff & !clr);
    m_fp = pe   | (m_fp & !clr);
    m_fo = lost | (m_fo & !clr);
    if (rd) m_arm = 0; else if (rs && anyf) m_arm = 1;
    @(negedge clk);
    frm_valid = 0; rd_stat = 0; rd_data = 0;
    compare();
  endtask

  task automatic frame(input int d, input bit stop, input bit pok, input bit nz,
                       input bit pen, input bit bke);
    cyc(1, d, stop, pok, nz, pen, bke, 0, 0);
  endtask

  task automatic idle(); cyc(0, 0, 1, 1, 0, 0, 0, 0, 0); endtask
  task automatic sread(); cyc(0, 0, 1, 1, 0, 0, 0, 1, 0); endtask
  task automatic dread(); cyc(0, 0, 1, 1, 0, 0, 0, 0, 1); endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) dread();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state during and after reset
    repeat (3) @(negedge clk);
    chk({err_noise, err_frame, err_parity, err_overrun, rx_avail} == 5'b0,
        "R1 reset outputs", {err_noise, err_frame, err_parity, err_overrun, rx_avail}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare();

    // R2: ordering, head view and pop; rd_data on empty is harmless
    dread();
    frame(8'hA1, 1, 1, 0, 0, 0);
    frame(8'hB2, 1, 1, 0, 0, 0);
    frame(8'hC3, 1, 1, 0, 0, 0);
    idle();
    drain();

    // R5: parity flag needs enable and break detect off
    frame(8'h11, 1, 0, 0, 0, 0);
    frame(8'h22, 1, 0, 0, 1, 1);
    frame(8'h33, 1, 0, 0, 1, 0);
    // R6: noise flag and tag
    frame(8'h44, 1, 1, 1, 0, 0);
    // R8: data read without arm leaves flags, then status + data clears
    dread();
    sread();
    idle();
    dread();
    drain();

    // R3: framing, suppressed by break detect, then set; word still stored
    frame(8'h55, 0, 1, 0, 0, 1);
    frame(8'h66, 0, 1, 0, 0, 0);
    // R4: frames are dropped while the framing flag is set
    frame(8'h77, 1, 0, 1, 1, 0);
    frame(8'h78, 0, 1, 0, 0, 0);
    sread();
    sread();
    dread();
    frame(8'h79, 1, 1, 0, 0, 0);
    drain();

    // R7: overrun on a full buffer, no other flag updated
    for (int i = 0; i < 4; i++) frame(8'h80 + i, 1, 1, 0, 0, 0);
    frame(8'h90, 0, 0, 1, 1, 0);
    // full buffer with a same-cycle data read: accepted
    cyc(1, 8'h91, 1, 0, 0, 1, 0, 0, 1);
    sread();
    dread();
    drain();

    // R9: set on the same edge as the clearing data read wins
    frame(8'hA0, 1, 1, 1, 0, 0);
    sread();
    cyc(1, 8'hA5, 1, 0, 1, 1, 0, 0, 1);
    idle();
    sread();
    dread();
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule